// File: doc/BRIEF.md
# Endpoint Packet Buffer Data Port

This block is the processor-side data port of one endpoint's packet buffers. On the transmit side, processor writes of 1, 2 or 4 bytes are packed in order into a byte-addressed packet slot. When software raises `tx_pkt_rdy`, the slot is handed to the line-side engine. That engine pops the packet one byte at a time and sees a marker on the final byte. On the receive side, the line engine pushes bytes and closes each packet with an end marker. Software then reads the packet back through the same port, at any of the three widths, with the bytes unpacked little-endian onto the data lanes.

Each direction has two slots. With `dbl_buf` low, only one packet is held at a time. With `dbl_buf` high, the slots alternate: one packet is being filled while the other waits or drains. The port enforces a width rule inside each packet. It drops writes that do not fit and answers reads from an empty receive side with zero. Each of these events raises a sticky flag. `tx_flush` discards every transmit packet, whether committed or partly written, as is needed after a stall handshake or a transmit error.

Top module: `ep_fifo_port`

## Requirements
- R1: After reset, `cpu_rdata` is zero, `width_err`, `underrun` and `overrun` are low, and `tx_avail` and `rx_avail` are low.
- R2: `cpu_size` codes are: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A write accepted with code c appends bytes from lane 0 upward, where lane k is `cpu_wdata[8k+7:8k]`. Upper lanes are ignored. The line side pops bytes in write order on `tx_byte`, and `tx_last` is high with the final byte of the packet.
- R3: A `tx_pkt_rdy` pulse while the slot being filled is not already committed makes `tx_avail` high from the next cycle.
- R4: A write is dropped and sets sticky `overrun` when the slot being filled is committed, or when the write's bytes would exceed PKT_BYTES. Already stored packets are unchanged.
- R5: With `dbl_buf` low, at most one transmit packet is committed. With it high, two packets may be committed, and they drain in commit order.
- R6: `tx_flush` empties every transmit slot, including a partly written one, so that `tx_avail` is low the next cycle and the next packet starts empty.
- R7: Within one transmit packet, `width_err` is set when an access is wider than the previous access in that packet. It is also set when an access repeats the width of a previous access that was narrower than the first. `width_err` clears on commit or flush.
- R8: The same width rule applies to reads of one receive packet, and `rx_release` clears it.
- R9: A read of a committed receive packet returns, one cycle later on `cpu_rdata`, the next bytes in little-endian lane order. `rx_count` shows the byte count of the head packet.
- R10: Lanes beyond the head packet's remaining bytes read as zero. A read past the end returns zero and stays on the same packet until `rx_release`.
- R11: A read with no committed receive packet returns zero and sets sticky `underrun`.
- R12: The receive side holds at most one packet with `dbl_buf` low and two with it high. A pushed byte is dropped when the fill slot is committed or already holds PKT_BYTES bytes. An end marker is ignored when the fill slot is committed.
- R13: `overrun` and `underrun` stay set until `err_clr`. A new setting event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_buf | input | 1 | 1 = two packet slots per direction, 0 = one |
| cpu_wr | input | 1 | Processor write strobe (transmit push) |
| cpu_rd | input | 1 | Processor read strobe (receive pop) |
| cpu_size | input | 2 | Access width code: 0 byte, 1 halfword, 2/3 word |
| cpu_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| cpu_rdata | output | 32 | Read data, registered, valid the cycle after `cpu_rd` |
| tx_pkt_rdy | input | 1 | Commit the transmit packet being filled |
| tx_flush | input | 1 | Discard all transmit contents |
| err_clr | input | 1 | Clear the sticky `overrun` and `underrun` flags |
| tx_pop | input | 1 | Line side takes the current transmit byte |
| tx_avail | output | 1 | A committed transmit packet is at the head |
| tx_byte | output | 8 | Current transmit byte |
| tx_last | output | 1 | Current byte is the last of its packet |
| rx_push | input | 1 | Line side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | Closes the received packet (with or without a byte) |
| rx_release | input | 1 | Software frees the head receive packet |
| rx_avail | output | 1 | A committed receive packet is at the head |
| rx_count | output | $clog2(PKT_BYTES+1) | Byte count of the head receive packet, 0 if none |
| width_err | output | 1 | Width rule broken in the current packet |
| underrun | output | 1 | Sticky: read with nothing to read |
| overrun | output | 1 | Sticky: write dropped |

## Verification
The hardest state to reach from the ports is a full double-buffered transmit side: one slot is committed and waiting, the other is committed behind it, and a further write must be dropped without disturbing either one. The stimulus commits two packets of different lengths and widths back to back with no pops between them. It then writes once more and drains both packets, checking every byte against its arithmetic pattern. Sweeps over every access width and every packet length from 1 to PKT_BYTES, in both buffering modes, reach the odd tail splits. For example, a word packet of 3 leftover bytes ends as a halfword followed by a byte.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;

  localparam int LANES = 4;

  // Code 3 is treated as a full word.
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  function automatic logic [2:0] lane_count(input logic [1:0] sz);
    case (norm_size(sz))
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Width rule: no widening, and no repeat of a width that was already short.
  function automatic logic width_bad(input logic [1:0] first_sz,
                                     input logic [1:0] prev_sz,
                                     input logic [1:0] cur_sz);
    return (cur_sz > prev_sz) || ((cur_sz == prev_sz) && (prev_sz < first_sz));
  endfunction

endpackage

// File: rtl/ep_width_track.sv
module ep_width_track
  import ep_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [1:0] sz,
  input  logic       clr,
  output logic       err
);

  logic       active;
  logic [1:0] first_sz;
  logic [1:0] prev_sz;
  logic [1:0] cur_sz;
  logic       bad;

  assign cur_sz = norm_size(sz);
  assign bad    = active && width_bad(first_sz, prev_sz, cur_sz);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active   <= 1'b0;
      first_sz <= 2'd0;
      prev_sz  <= 2'd0;
      err      <= 1'b0;
    end else if (acc) begin
      active  <= 1'b1;
      prev_sz <= cur_sz;
      if (!active) first_sz <= cur_sz;
      if (bad)     err      <= 1'b1;
    end
  end

endmodule

// File: rtl/ep_tx_packer.sv
module ep_tx_packer
  import ep_fifo_pkg::*;
#(
  parameter int PKT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbl_buf,
  input  logic        wr,
  input  logic [1:0]  sz,
  input  logic [31:0] wdata,
  input  logic        commit,
  input  logic        flush,
  input  logic        pop,
  output logic        avail,
  output logic [7:0]  byte_out,
  output logic        last,
  output logic        accept_ev,
  output logic        drop_ev,
  output logic        commit_ev,
  output logic        fill_busy,
  output logic [1:0]  busy
);

  localparam int IW  = $clog2(PKT_BYTES);
  localparam int CW  = $clog2(PKT_BYTES + 1);
  localparam int CW1 = CW + 1;

  logic [7:0]    mem [2][PKT_BYTES];
  logic [CW-1:0] cnt [2];
  logic [1:0]    busy_q;
  logic          fill_sel;
  logic          send_sel;
  logic [CW-1:0] rd_idx;

  logic [2:0]    nb;
  logic [CW-1:0] fill_cnt;
  logic [CW-1:0] send_cnt;
  logic          fits;
  logic          pop_ok;
  logic          pop_end;
  logic [CW-1:0] lane_pos [LANES];
  logic [LANES-1:0] lane_we;

  assign nb        = lane_count(sz);
  assign fill_cnt  = cnt[fill_sel];
  assign send_cnt  = cnt[send_sel];
  assign fill_busy = busy_q[fill_sel];
  assign fits      = ({1'b0, fill_cnt} + CW1'(nb)) <= CW1'(PKT_BYTES);
  assign drop_ev   = wr && (fill_busy || !fits);
  assign accept_ev = wr && !drop_ev;
  assign commit_ev = commit && !fill_busy;

  assign avail    = busy_q[send_sel];
  assign byte_out = mem[send_sel][rd_idx[IW-1:0]];
  assign last     = avail && (({1'b0, rd_idx} + CW1'(1)) >= {1'b0, send_cnt});
  assign pop_ok   = pop && avail;
  assign pop_end  = pop_ok && last;
  assign busy     = busy_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_pos[k] = fill_cnt + CW'(k);
    assign lane_we[k]  = accept_ev && (3'(k) < nb);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_we[k]) mem[fill_sel][lane_pos[k][IW-1:0]] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy_q   <= 2'b00;
      fill_sel <= 1'b0;
      send_sel <= 1'b0;
      rd_idx   <= '0;
      for (int s = 0; s < 2; s++) cnt[s] <= '0;
    end else begin
      if (accept_ev) cnt[fill_sel] <= fill_cnt + CW'(nb);
      if (commit_ev) begin
        busy_q[fill_sel] <= 1'b1;
        if (dbl_buf) fill_sel <= ~fill_sel;
      end
      if (pop_end) begin
        busy_q[send_sel] <= 1'b0;
        cnt[send_sel]    <= '0;
        rd_idx           <= '0;
        if (dbl_buf) send_sel <= ~send_sel;
      end else if (pop_ok) begin
        rd_idx <= rd_idx + CW'(1);
      end
    end
  end

endmodule

// File: rtl/ep_rx_unpacker.sv
module ep_rx_unpacker
  import ep_fifo_pkg::*;
#(
  parameter int PKT_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl_buf,
  input  logic          push,
  input  logic [7:0]    byte_in,
  input  logic          eop,
  input  logic          rd,
  input  logic [1:0]    sz,
  input  logic          rel,
  output logic          avail,
  output logic [$clog2(PKT_BYTES+1)-1:0] count,
  output logic [31:0]   rdata,
  output logic          empty_rd_ev,
  output logic          hit_rd_ev,
  output logic          rel_ev,
  output logic [1:0]    busy
);

  localparam int IW = $clog2(PKT_BYTES);
  localparam int CW = $clog2(PKT_BYTES + 1);

  logic [7:0]    mem [2][PKT_BYTES];
  logic [CW-1:0] cnt [2];
  logic [1:0]    busy_q;
  logic          fill_sel;
  logic          rd_sel;
  logic [CW-1:0] rd_idx;

  logic          push_ok;
  logic          eop_ok;
  logic [2:0]    nb;
  logic [CW-1:0] head_cnt;
  logic [CW-1:0] left;
  logic [2:0]    take;
  logic [CW-1:0] lane_pos [LANES];
  logic [7:0]    lane_val [LANES];
  logic [31:0]   rd_word;

  assign push_ok  = push && !busy_q[fill_sel] && (cnt[fill_sel] < CW'(PKT_BYTES));
  assign eop_ok   = eop && !busy_q[fill_sel];
  assign avail    = busy_q[rd_sel];
  assign head_cnt = cnt[rd_sel];
  assign count    = avail ? head_cnt : '0;
  assign nb       = lane_count(sz);
  assign left     = head_cnt - rd_idx;
  assign take     = (left < CW'(nb)) ? left[2:0] : nb;

  assign empty_rd_ev = rd && !avail;
  assign hit_rd_ev   = rd && avail;
  assign rel_ev      = rel && avail;
  assign busy        = busy_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_pos[k] = rd_idx + CW'(k);
    assign lane_val[k] = (3'(k) < take) ? mem[rd_sel][lane_pos[k][IW-1:0]] : 8'h00;
    assign rd_word[8*k +: 8] = lane_val[k];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[fill_sel][cnt[fill_sel][IW-1:0]] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 2'b00;
      fill_sel <= 1'b0;
      rd_sel   <= 1'b0;
      rd_idx   <= '0;
      rdata    <= '0;
      for (int s = 0; s < 2; s++) cnt[s] <= '0;
    end else begin
      if (push_ok) cnt[fill_sel] <= cnt[fill_sel] + CW'(1);
      if (eop_ok) begin
        busy_q[fill_sel] <= 1'b1;
        if (dbl_buf) fill_sel <= ~fill_sel;
      end
      if (rd) rdata <= hit_rd_ev ? rd_word : 32'h0;
      if (hit_rd_ev) rd_idx <= rd_idx + CW'(take);
      if (rel_ev) begin
        busy_q[rd_sel] <= 1'b0;
        cnt[rd_sel]    <= '0;
        rd_idx         <= '0;
        if (dbl_buf) rd_sel <= ~rd_sel;
      end
    end
  end

endmodule

// File: rtl/ep_fifo_port.sv
module ep_fifo_port
  import ep_fifo_pkg::*;
#(
  parameter int PKT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbl_buf,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  input  logic        tx_pkt_rdy,
  input  logic        tx_flush,
  input  logic        err_clr,
  input  logic        tx_pop,
  output logic        tx_avail,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_eop,
  input  logic        rx_release,
  output logic        rx_avail,
  output logic [$clog2(PKT_BYTES+1)-1:0] rx_count,
  output logic        width_err,
  output logic        underrun,
  output logic        overrun
);

  // Internal events, named for the checker.
  logic       tx_accept_ev;
  logic       tx_drop_ev;
  logic       tx_commit_ev;
  logic       tx_fill_busy;
  logic [1:0] tx_busy;
  logic       rx_empty_rd_ev;
  logic       rx_hit_rd_ev;
  logic       rx_rel_ev;
  logic [1:0] rx_busy;
  logic       tx_werr;
  logic       rx_werr;

  ep_tx_packer #(.PKT_BYTES(PKT_BYTES)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_buf   (dbl_buf),
    .wr        (cpu_wr),
    .sz        (cpu_size),
    .wdata     (cpu_wdata),
    .commit    (tx_pkt_rdy),
    .flush     (tx_flush),
    .pop       (tx_pop),
    .avail     (tx_avail),
    .byte_out  (tx_byte),
    .last      (tx_last),
    .accept_ev (tx_accept_ev),
    .drop_ev   (tx_drop_ev),
    .commit_ev (tx_commit_ev),
    .fill_busy (tx_fill_busy),
    .busy      (tx_busy)
  );

  ep_rx_unpacker #(.PKT_BYTES(PKT_BYTES)) rx_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbl_buf     (dbl_buf),
    .push        (rx_push),
    .byte_in     (rx_byte),
    .eop         (rx_eop),
    .rd          (cpu_rd),
    .sz          (cpu_size),
    .rel         (rx_release),
    .avail       (rx_avail),
    .count       (rx_count),
    .rdata       (cpu_rdata),
    .empty_rd_ev (rx_empty_rd_ev),
    .hit_rd_ev   (rx_hit_rd_ev),
    .rel_ev      (rx_rel_ev),
    .busy        (rx_busy)
  );

  ep_width_track tx_wt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (tx_accept_ev),
    .sz    (cpu_size),
    .clr   (tx_commit_ev || tx_flush),
    .err   (tx_werr)
  );

  ep_width_track rx_wt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (rx_hit_rd_ev),
    .sz    (cpu_size),
    .clr   (rx_rel_ev),
    .err   (rx_werr)
  );

  assign width_err = tx_werr || rx_werr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (tx_drop_ev)   overrun <= 1'b1;
      else if (err_clr) overrun <= 1'b0;
      if (rx_empty_rd_ev) underrun <= 1'b1;
      else if (err_clr)   underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/ep_fifo_port_chk.sv
module ep_fifo_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dbl_buf,
  input logic        cpu_rd,
  input logic [31:0] cpu_rdata,
  input logic        tx_pkt_rdy,
  input logic        tx_flush,
  input logic        err_clr,
  input logic        tx_avail,
  input logic        rx_avail,
  input logic        underrun,
  input logic        overrun,
  input logic        tx_drop_ev,
  input logic        tx_fill_busy,
  input logic [1:0]  tx_busy,
  input logic [1:0]  rx_busy
);

  // R11
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !rx_avail) |=> (underrun && (cpu_rdata == 32'h0)));

  // R13
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr) |=> underrun);

  // R13
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);

  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop_ev |=> overrun);

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> !tx_avail);

  // R3
  commit_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pkt_rdy && !tx_flush && !tx_fill_busy) |=> tx_avail);

  // R5
  tx_single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_buf |-> ($countones(tx_busy) <= 1));

  // R12
  rx_single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_buf |-> ($countones(rx_busy) <= 1));

endmodule

bind ep_fifo_port ep_fifo_port_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbl_buf      (dbl_buf),
  .cpu_rd       (cpu_rd),
  .cpu_rdata    (cpu_rdata),
  .tx_pkt_rdy   (tx_pkt_rdy),
  .tx_flush     (tx_flush),
  .err_clr      (err_clr),
  .tx_avail     (tx_avail),
  .rx_avail     (rx_avail),
  .underrun     (underrun),
  .overrun      (overrun),
  .tx_drop_ev   (tx_drop_ev),
  .tx_fill_busy (tx_fill_busy),
  .tx_busy      (tx_busy),
  .rx_busy      (rx_busy)
);

// File: tb/ep_fifo_port_tb.sv
module ep_fifo_port_tb_top;

  localparam int PB = 8;
  localparam int CW = $clog2(PB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbl_buf = 1'b0;
  logic          cpu_wr = 1'b0;
  logic          cpu_rd = 1'b0;
  logic [1:0]    cpu_size = 2'd0;
  logic [31:0]   cpu_wdata = 32'h0;
  logic [31:0]   cpu_rdata;
  logic          tx_pkt_rdy = 1'b0;
  logic          tx_flush = 1'b0;
  logic          err_clr = 1'b0;
  logic          tx_pop = 1'b0;
  logic          tx_avail;
  logic [7:0]    tx_byte;
  logic          tx_last;
  logic          rx_push = 1'b0;
  logic [7:0]    rx_byte = 8'h0;
  logic          rx_eop = 1'b0;
  logic          rx_release = 1'b0;
  logic          rx_avail;
  logic [CW-1:0] rx_count;
  logic          width_err;
  logic          underrun;
  logic          overrun;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ep_fifo_port #(.PKT_BYTES(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbl_buf(dbl_buf),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_pkt_rdy(tx_pkt_rdy), .tx_flush(tx_flush), .err_clr(err_clr),
    .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_last(tx_last),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rx_release(rx_release), .rx_avail(rx_avail), .rx_count(rx_count),
    .width_err(width_err), .underrun(underrun), .overrun(overrun)
  );

  function automatic logic [7:0] pat(input int pk, input int i);
    return 8'((pk * 37 + i * 11 + 3) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cpu_write(input int code, input logic [31:0] d);
    cpu_wr = 1'b1; cpu_size = code[1:0]; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input int code, output logic [31:0] d);
    cpu_rd = 1'b1; cpu_size = code[1:0];
    tick();
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic commit();
    tx_pkt_rdy = 1'b1; tick(); tx_pkt_rdy = 1'b0;
  endtask

  task automatic flush();
    tx_flush = 1'b1; tick(); tx_flush = 1'b0;
  endtask

  task automatic release_rx();
    rx_release = 1'b1; tick(); rx_release = 1'b0;
  endtask

  task automatic clear_flags();
    err_clr = 1'b1; tick(); err_clr = 1'b0;
  endtask

  // Splits len bytes into accesses of width 2**sz, narrowing only for the tail.
  task automatic write_packet(input int pk, input int len, input int sz);
    int i;
    i = 0;
    while (i < len) begin
      int rem;
      int n;
      int code;
      logic [31:0] d;
      rem  = len - i;
      n    = 1 << sz;
      code = sz;
      while (n > rem) begin
        n = n / 2;
        code--;
      end
      d = 32'hEEEE_EEEE;
      for (int k = 0; k < n; k++) d[8*k +: 8] = pat(pk, i + k);
      cpu_write(code, d);
      i += n;
    end
  endtask

  task automatic pop_check(input int pk, input int len, input string req);
    for (int i = 0; i < len; i++) begin
      chk(req, 32'(tx_byte), 32'(pat(pk, i)));
      chk(req, 32'(tx_last), 32'(i == len - 1));
      tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    end
  endtask

  task automatic push_packet(input int pk, input int len);
    for (int i = 0; i < len; i++) begin
      rx_push = 1'b1; rx_byte = pat(pk, i); rx_eop = (i == len - 1);
      tick();
    end
    rx_push = 1'b0; rx_eop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] e;
    int pk;
    pk = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 rdata", cpu_rdata, 32'h0);
    chk("R1 flags", {29'h0, width_err, underrun, overrun}, 32'h0);
    chk("R1 avail", {30'h0, tx_avail, rx_avail}, 32'h0);

    // R2 R3 transmit sweep: both modes, every width, every length
    for (int d = 0; d < 2; d++) begin
      dbl_buf = d[0];
      flush();
      for (int s = 0; s < 3; s++) begin
        for (int len = 1; len <= PB; len++) begin
          pk++;
          write_packet(pk, len, s);
          chk("R7 legal tail split", 32'(width_err), 32'h0);
          commit();
          chk("R3 avail after commit", 32'(tx_avail), 32'h1);
          pop_check(pk, len, "R2 packed byte order");
          chk("R2 drained", 32'(tx_avail), 32'h0);
        end
      end
    end
    chk("R4 no overrun in sweep", 32'(overrun), 32'h0);

    // R4 R5 single mode: second packet dropped while first is committed
    dbl_buf = 1'b0; flush();
    write_packet(100, 8, 2); commit();
    cpu_write(0, 32'h0000_00AA);
    chk("R4 overrun on committed slot", 32'(overrun), 32'h1);
    pop_check(100, 8, "R4 stored packet intact");
    chk("R5 single mode one packet", 32'(tx_avail), 32'h0);
    cpu_write(0, 32'h0); tick();
    chk("R13 overrun sticky", 32'(overrun), 32'h1);
    clear_flags();
    chk("R13 overrun cleared", 32'(overrun), 32'h0);
    flush();

    // R4 size overflow
    write_packet(101, 7, 0);
    cpu_write(1, 32'h0000_5555);
    chk("R4 overrun on size", 32'(overrun), 32'h1);
    commit();
    pop_check(101, 7, "R4 partial packet intact");
    clear_flags();

    // R5 double mode: two packets, third write dropped, drained in order
    dbl_buf = 1'b1; flush();
    write_packet(102, 5, 1); commit();
    write_packet(103, 3, 0); commit();
    chk("R5 no overrun with two slots", 32'(overrun), 32'h0);
    cpu_write(2, 32'h1234_5678);
    chk("R5 third packet dropped", 32'(overrun), 32'h1);
    pop_check(102, 5, "R5 first packet");
    chk("R5 second waiting", 32'(tx_avail), 32'h1);
    pop_check(103, 3, "R5 second packet");
    chk("R5 empty", 32'(tx_avail), 32'h0);
    clear_flags();

    // R6 flush discards committed and partial data
    write_packet(104, 4, 2); commit();
    write_packet(105, 2, 1);
    flush();
    chk("R6 flushed", 32'(tx_avail), 32'h0);
    write_packet(106, 3, 0); commit();
    pop_check(106, 3, "R6 fresh packet after flush");

    // R7 write width rule
    dbl_buf = 1'b0; flush();
    cpu_write(1, 32'h0); cpu_write(2, 32'h0);
    chk("R7 widening flagged", 32'(width_err), 32'h1);
    commit();
    chk("R7 cleared by commit", 32'(width_err), 32'h0);
    flush();
    cpu_write(2, 32'h0); cpu_write(1, 32'h0);
    chk("R7 short tail legal", 32'(width_err), 32'h0);
    cpu_write(1, 32'h0);
    chk("R7 repeat of short flagged", 32'(width_err), 32'h1);
    flush();
    chk("R7 cleared by flush", 32'(width_err), 32'h0);
    cpu_write(0, 32'h0); cpu_write(0, 32'h0); cpu_write(0, 32'h0);
    chk("R7 byte packet legal", 32'(width_err), 32'h0);
    flush();

    // R9 R10 receive sweep
    for (int d = 0; d < 2; d++) begin
      dbl_buf = d[0];
      for (int s = 0; s < 3; s++) begin
        for (int len = 1; len <= PB; len++) begin
          int idx;
          pk++;
          push_packet(pk, len);
          chk("R9 rx_count", 32'(rx_count), 32'(len));
          idx = 0;
          while (idx < len) begin
            int n;
            n = (1 << s);
            if (n > len - idx) n = len - idx;
            e = 32'h0;
            for (int k = 0; k < n; k++) e[8*k +: 8] = pat(pk, idx + k);
            cpu_read(s, r);
            chk("R9 unpacked lanes", r, e);
            idx += n;
          end
          cpu_read(s, r);
          chk("R10 read past end", r, 32'h0);
          chk("R10 same packet", 32'(rx_count), 32'(len));
          chk("R8 no width error", 32'(width_err), 32'h0);
          release_rx();
          chk("R9 released", 32'(rx_avail), 32'h0);
        end
      end
    end
    chk("R11 no underrun in sweep", 32'(underrun), 32'h0);

    // R8 read width rule
    push_packet(200, 4);
    cpu_read(1, r); cpu_read(2, r);
    chk("R8 widening read flagged", 32'(width_err), 32'h1);
    release_rx();
    chk("R8 cleared by release", 32'(width_err), 32'h0);

    // R11 underrun after a nonzero read
    push_packet(201, 1);
    cpu_read(0, r);
    chk("R9 single byte", r, 32'(pat(201, 0)));
    release_rx();
    cpu_read(2, r);
    chk("R11 empty read zero", r, 32'h0);
    chk("R11 underrun set", 32'(underrun), 32'h1);
    tick(); tick();
    chk("R13 underrun sticky", 32'(underrun), 32'h1);
    clear_flags();
    chk("R13 underrun cleared", 32'(underrun), 32'h0);

    // R12 single mode: overfull and blocked pushes dropped
    dbl_buf = 1'b0;
    push_packet(202, PB + 1);
    chk("R12 count capped", 32'(rx_count), 32'(PB));
    push_packet(203, 3);
    chk("R12 blocked while held", 32'(rx_count), 32'(PB));
    cpu_read(2, r);
    chk("R12 original data", r, {pat(202, 3), pat(202, 2), pat(202, 1), pat(202, 0)});
    release_rx();
    chk("R12 no second packet", 32'(rx_avail), 32'h0);

    // R12 double mode: two held, third dropped
    dbl_buf = 1'b1;
    push_packet(204, 3);
    push_packet(205, 5);
    push_packet(206, 2);
    chk("R12 first head", 32'(rx_count), 32'h3);
    cpu_read(0, r);
    chk("R12 first data", r, 32'(pat(204, 0)));
    release_rx();
    chk("R12 second head", 32'(rx_count), 32'h5);
    cpu_read(2, r);
    chk("R12 second data", r, {pat(205, 3), pat(205, 2), pat(205, 1), pat(205, 0)});
    release_rx();
    chk("R12 third dropped", 32'(rx_avail), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule